// File: doc/BRIEF.md
# Level-Match GPIO Controller

This block is a register-mapped general-purpose I/O controller for a bank of fourteen pins. Software reaches it through a plain word-addressed register bus with a one-cycle registered read path. Each pin can be run as a general-purpose pin, with a programmable direction and output value, or it can be handed to a fixed peripheral function: a serial port transmit/receive pair with its flow-control lines, or the upper bits of an external address bus.

Every pin input passes through a two-stage synchroniser. The synchronised value feeds the data readback and a per-pin comparison against a programmable level. Whenever a pin equals its level, a sticky status bit is set, and software clears it by writing a one to that bit. Any status bit whose enable bit is also set raises the non-maskable interrupt output.

Register map (byte offsets; bit n of every register belongs to pin n; bits 14 to 31 read as zero): 0x00 function select (1 = peripheral), 0x04 direction (1 = output), 0x08 pin data, 0x0C match level, 0x10 match status, 0x14 interrupt enable.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After synchronous reset every register and both synchroniser stages are zero: pad_oe and pad_out are 0, nmi_irq is 0, bus_rdata is 0, and the peripheral inputs per_uart_rxd and per_uart_cts_n are 1.
- R2: A write with bus_sel=1 and bus_wr=1 updates the register at the decoded offset (0x00, 0x04, 0x0C and 0x14 read back as written). A read with bus_sel=1 and bus_wr=0 returns that register on bus_rdata in the following cycle, and bus_rdata is 0 in any cycle after a cycle with no read. Bits 14 to 31 always read as 0.
- R3: Offsets 0x18 and above read as 0, and writes to them change no register. Address bits 1:0 are ignored.
- R4: For a pin whose function bit is 0, pad_oe equals its direction bit and pad_out equals the last value written to its bit of the data register (offset 0x08).
- R5: Reading offset 0x08 returns the pad_in value delayed by two clock edges through the synchroniser, not the written output value.
- R6: A status bit (offset 0x10) is set at the clock edge after the synchronised pin equals its level bit (offset 0x0C), and it stays set when the match goes away.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the match holds in the same cycle as the clearing write, the bit stays set.
- R8: nmi_irq is 1 exactly when some pin has both its status bit and its enable bit (offset 0x14) set.
- R9: For a pin whose function bit is 1: pin 0 drives per_uart_txd, pin 2 drives per_uart_rts_n, and pins 4 to 7 drive per_addr_hi[0] to [3], with pad_oe=1 on all of these. Pins 1 and 3 are inputs (pad_oe=0).
- R10: per_uart_rxd follows synchronised pin 1 and per_uart_cts_n follows synchronised pin 3 while that pin's function bit is 1. Otherwise each is held at 1.
- R11: Pins 8 to 13 with function bit 1 have no peripheral: pad_oe=0 and pad_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_in | input | 14 | Raw pin levels from the pads |
| pad_out | output | 14 | Value driven toward the pads |
| pad_oe | output | 14 | Pad output enable per pin |
| nmi_irq | output | 1 | Non-maskable interrupt request |
| per_uart_txd | input | 1 | Serial transmit from the UART |
| per_uart_rts_n | input | 1 | Request-to-send from the UART |
| per_uart_rxd | output | 1 | Serial receive toward the UART |
| per_uart_cts_n | output | 1 | Clear-to-send toward the UART |
| per_addr_hi | input | 4 | Upper address bits 22 to 25 from the bus master |

## Verification
A register write takes effect at the edge that samples it, so pad_oe, pad_out and nmi_irq reflect it one edge later, and a read returns its data one edge after the request. A pad change is seen by the data readback, the peripheral inputs and the match logic only after two synchroniser edges, and a status bit sets one edge later still. The bench keeps a cycle-exact reference model that advances at each rising edge. It compares outputs one time unit after that edge and drives inputs on the falling edge. Directed checks hold a pad steady for at least three edges before they read. The set-versus-clear ordering is checked with a write immediately followed by a read.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned NUM_REGS = 6;

    // Peripheral pin assignment (behavioural: the pad mux decodes these).
    localparam int unsigned ALT_TXD_PIN = 0;
    localparam int unsigned ALT_RXD_PIN = 1;
    localparam int unsigned ALT_RTS_PIN = 2;
    localparam int unsigned ALT_CTS_PIN = 3;
    localparam int unsigned ALT_ADR_LO  = 4;
    localparam int unsigned ALT_ADR_N   = 4;

    typedef enum logic [2:0] {
        RI_FUNC  = 3'd0,
        RI_DIR   = 3'd1,
        RI_DATA  = 3'd2,
        RI_LEVEL = 3'd3,
        RI_STAT  = 3'd4,
        RI_NMIEN = 3'd5,
        RI_NONE  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        reg_idx_e          idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_idx_e decode_idx(input logic [ADDR_W-1:0] addr);
        logic [WORD_W-1:0] word;
        word = addr[ADDR_W-1:2];
        if (word < WORD_W'(NUM_REGS))
            return reg_idx_e'(word[2:0]);
        return RI_NONE;
    endfunction

    function automatic logic is_write(input bus_req_t r, input reg_idx_e which);
        return r.sel && r.wr && (r.idx == which);
    endfunction

endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
    parameter int unsigned WIDTH  = 14,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++)
                stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int s = 1; s < int'(STAGES); s++)
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned NP = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NP-1:0]     pin_s,
    input  logic [NP-1:0]     status,
    output logic [NP-1:0]     func_o,
    output logic [NP-1:0]     dir_o,
    output logic [NP-1:0]     dout_o,
    output logic [NP-1:0]     level_o,
    output logic [NP-1:0]     nmien_o,
    output logic              clr_en,
    output logic [NP-1:0]     clr_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - NP;

    logic [NP-1:0]     func_q, dir_q, dout_q, level_q, nmien_q;
    logic [DATA_W-1:0] rd_q;
    logic [NP-1:0]     wbits;
    logic [NP-1:0]     rd_sel;

    assign wbits = req.wdata[NP-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q  <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            level_q <= '0;
            nmien_q <= '0;
        end else begin
            if (is_write(req, RI_FUNC))  func_q  <= wbits;
            if (is_write(req, RI_DIR))   dir_q   <= wbits;
            if (is_write(req, RI_DATA))  dout_q  <= wbits;
            if (is_write(req, RI_LEVEL)) level_q <= wbits;
            if (is_write(req, RI_NMIEN)) nmien_q <= wbits;
        end
    end

    // Read mux: data offset returns synchronised pins, not the output latch.
    always_comb begin
        unique case (req.idx)
            RI_FUNC:  rd_sel = func_q;
            RI_DIR:   rd_sel = dir_q;
            RI_DATA:  rd_sel = pin_s;
            RI_LEVEL: rd_sel = level_q;
            RI_STAT:  rd_sel = status;
            RI_NMIEN: rd_sel = nmien_q;
            default:  rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (req.sel && !req.wr)
            rd_q <= {{PAD_W{1'b0}}, rd_sel};
        else
            rd_q <= '0;
    end

    assign clr_en   = is_write(req, RI_STAT);
    assign clr_mask = wbits;
    assign func_o   = func_q;
    assign dir_o    = dir_q;
    assign dout_o   = dout_q;
    assign level_o  = level_q;
    assign nmien_o  = nmien_q;
    assign rdata    = rd_q;
endmodule

// File: rtl/gpio_lvl_stat.sv
module gpio_lvl_stat #(
    parameter int unsigned NP = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] pin_s,
    input  logic [NP-1:0] level,
    input  logic          clr_en,
    input  logic [NP-1:0] clr_mask,
    input  logic [NP-1:0] nmien,
    output logic [NP-1:0] status,
    output logic          nmi
);
    logic [NP-1:0] stat_q;
    logic [NP-1:0] hit;
    logic [NP-1:0] keep;

    assign hit  = ~(pin_s ^ level);
    assign keep = clr_en ? (stat_q & ~clr_mask) : stat_q;

    // Set term is OR-ed after the clear, so a live match wins.
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= keep | hit;
    end

    assign status = stat_q;
    assign nmi    = |(stat_q & nmien);
endmodule

// File: rtl/gpio_lvl_mux.sv
module gpio_lvl_mux
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned NP = 14
) (
    input  logic                 clk,
    input  logic [NP-1:0]        func,
    input  logic [NP-1:0]        dir,
    input  logic [NP-1:0]        dout,
    input  logic [NP-1:0]        pin_s,
    input  logic                 per_txd,
    input  logic                 per_rts_n,
    input  logic [ALT_ADR_N-1:0] per_addr,
    output logic [NP-1:0]        pad_out,
    output logic [NP-1:0]        pad_oe,
    output logic                 per_rxd,
    output logic                 per_cts_n
);
    logic [NP-1:0] alt_out;
    logic [NP-1:0] alt_oe;
    logic          unused_clk;

    assign unused_clk = clk;

    for (genvar i = 0; i < int'(NP); i++) begin : g_pin
        if (i == int'(ALT_TXD_PIN)) begin : g_txd
            assign alt_out[i] = per_txd;
            assign alt_oe[i]  = 1'b1;
        end else if (i == int'(ALT_RTS_PIN)) begin : g_rts
            assign alt_out[i] = per_rts_n;
            assign alt_oe[i]  = 1'b1;
        end else if (i >= int'(ALT_ADR_LO) && i < int'(ALT_ADR_LO + ALT_ADR_N)) begin : g_adr
            assign alt_out[i] = per_addr[i - int'(ALT_ADR_LO)];
            assign alt_oe[i]  = 1'b1;
        end else begin : g_in
            // Receive-side peripheral pins and pins without a peripheral.
            assign alt_out[i] = 1'b0;
            assign alt_oe[i]  = 1'b0;
        end

        always_comb begin
            if (func[i]) begin
                pad_out[i] = alt_out[i];
                pad_oe[i]  = alt_oe[i];
            end else begin
                pad_out[i] = dout[i];
                pad_oe[i]  = dir[i];
            end
        end
    end

    assign per_rxd   = func[ALT_RXD_PIN] ? pin_s[ALT_RXD_PIN] : 1'b1;
    assign per_cts_n = func[ALT_CTS_PIN] ? pin_s[ALT_CTS_PIN] : 1'b1;
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic                 nmi_irq,
    input  logic                 per_uart_txd,
    input  logic                 per_uart_rts_n,
    output logic                 per_uart_rxd,
    output logic                 per_uart_cts_n,
    input  logic [ALT_ADR_N-1:0] per_addr_hi
);
    bus_req_t            req;
    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] func_q, dir_q, dout_q, level_q, nmien_q;
    logic [NUM_PINS-1:0] stat_q;
    logic [NUM_PINS-1:0] clr_mask;
    logic                clr_en;

    always_comb begin
        req.sel   = bus_sel;
        req.wr    = bus_wr;
        req.idx   = decode_idx(bus_addr);
        req.wdata = bus_wdata;
    end

    gpio_lvl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   (pad_in),
        .d_sync (pin_s)
    );

    gpio_lvl_regs #(.NP(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .pin_s    (pin_s),
        .status   (stat_q),
        .func_o   (func_q),
        .dir_o    (dir_q),
        .dout_o   (dout_q),
        .level_o  (level_q),
        .nmien_o  (nmien_q),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata)
    );

    gpio_lvl_stat #(.NP(NUM_PINS)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .pin_s    (pin_s),
        .level    (level_q),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .nmien    (nmien_q),
        .status   (stat_q),
        .nmi      (nmi_irq)
    );

    gpio_lvl_mux #(.NP(NUM_PINS)) u_mux (
        .clk       (clk),
        .func      (func_q),
        .dir       (dir_q),
        .dout      (dout_q),
        .pin_s     (pin_s),
        .per_txd   (per_uart_txd),
        .per_rts_n (per_uart_rts_n),
        .per_addr  (per_addr_hi),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .per_rxd   (per_uart_rxd),
        .per_cts_n (per_uart_cts_n)
    );
endmodule

// File: rtl/gpio_lvl_chk.sv
module gpio_lvl_chk
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned NP = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NP-1:0]     status,
    input logic [NP-1:0]     func,
    input logic [NP-1:0]     pad_oe,
    input logic              nmi_irq
);
    logic stat_wr;
    assign stat_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4));

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(!(bus_sel && !bus_wr)) |-> (bus_rdata == '0)); // R2

    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NP] == '0); // R2

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((status & $past(status)) == $past(status))); // R6

    AST_NMI_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        nmi_irq |-> (status != '0)); // R8

    AST_ALT_TXD_DRIVES: assert property (@(posedge clk) disable iff (rst)
        func[ALT_TXD_PIN] |-> pad_oe[ALT_TXD_PIN]); // R9

    AST_ALT_RXD_INPUT: assert property (@(posedge clk) disable iff (rst)
        func[ALT_RXD_PIN] |-> !pad_oe[ALT_RXD_PIN]); // R9
endmodule

bind gpio_lvl_ctrl gpio_lvl_chk #(.NP(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .status    (stat_q),
    .func      (func_q),
    .pad_oe    (pad_oe),
    .nmi_irq   (nmi_irq)
);

// File: tb/gpio_lvl_ctrl_tb.sv
module gpio_lvl_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int NP    = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic        nmi_irq;
    logic        per_txd = 1'b0, per_rts_n = 1'b1;
    logic        per_rxd, per_cts_n;
    logic [3:0]  per_addr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run_chk = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_lvl_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .nmi_irq(nmi_irq),
        .per_uart_txd(per_txd), .per_uart_rts_n(per_rts_n),
        .per_uart_rxd(per_rxd), .per_uart_cts_n(per_cts_n), .per_addr_hi(per_addr)
    );

    // ---------------- reference model ----------------
    logic [NP-1:0] m_func, m_dir, m_dat, m_lvl, m_en, m_st, m_s1, m_s2;
    logic [31:0]   m_rd;
    string         m_tag = "R2";

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a[7:2])
            6'd0: return {18'b0, m_func};
            6'd1: return {18'b0, m_dir};
            6'd2: return {18'b0, m_s2};
            6'd3: return {18'b0, m_lvl};
            6'd4: return {18'b0, m_st};
            6'd5: return {18'b0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a[7:2])
            6'd2: return "R5";
            6'd4: return "R6/R7";
            6'd0, 6'd1, 6'd3, 6'd5: return "R2";
            default: return "R3";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_func <= '0; m_dir <= '0; m_dat <= '0; m_lvl <= '0; m_en <= '0;
            m_st <= '0; m_s1 <= '0; m_s2 <= '0; m_rd <= '0;
        end else begin
            logic [NP-1:0] match, wb;
            match = ~(m_s2 ^ m_lvl);
            wb    = bus_wdata[NP-1:0];
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            if (bus_sel && bus_wr) begin
                case (bus_addr[7:2])
                    6'd0: m_func <= wb;
                    6'd1: m_dir  <= wb;
                    6'd2: m_dat  <= wb;
                    6'd3: m_lvl  <= wb;
                    6'd5: m_en   <= wb;
                    default: ;
                endcase
            end
            if (bus_sel && bus_wr && bus_addr[7:2] == 6'd4)
                m_st <= (m_st & ~wb) | match;
            else
                m_st <= m_st | match;
            if (bus_sel && !bus_wr) begin
                m_rd  <= model_read(bus_addr);
                m_tag <= read_tag(bus_addr);
            end else begin
                m_rd  <= '0;
                m_tag <= "R2";
            end
        end
    end

    function automatic logic [2*NP-1:0] exp_pins();
        logic [NP-1:0] o, e;
        for (int i = 0; i < NP; i++) begin
            if (!m_func[i]) begin
                o[i] = m_dat[i]; e[i] = m_dir[i];
            end else if (i == 0) begin
                o[i] = per_txd; e[i] = 1'b1;
            end else if (i == 2) begin
                o[i] = per_rts_n; e[i] = 1'b1;
            end else if (i >= 4 && i <= 7) begin
                o[i] = per_addr[i-4]; e[i] = 1'b1;
            end else begin
                o[i] = 1'b0; e[i] = 1'b0;
            end
        end
        return {e, o};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst && run_chk) begin
            logic [2*NP-1:0] ep;
            ep = exp_pins();
            chk(m_tag, bus_rdata, m_rd);
            chk("R4/R9/R11 pad_out", {18'b0, pad_out}, {18'b0, ep[NP-1:0]});
            chk("R4/R9/R11 pad_oe", {18'b0, pad_oe}, {18'b0, ep[2*NP-1:NP]});
            chk("R8 nmi", {31'b0, nmi_irq}, {31'b0, |(m_st & m_en)});
            chk("R10 rxd", {31'b0, per_rxd}, {31'b0, m_func[1] ? m_s2[1] : 1'b1});
            chk("R10 cts_n", {31'b0, per_cts_n}, {31'b0, m_func[3] ? m_s2[3] : 1'b1});
        end
    end

    // ---------------- bus tasks (called at a falling edge) ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 pad_oe", {18'b0, pad_oe}, 32'h0);
        chk("R1 pad_out", {18'b0, pad_out}, 32'h0);
        chk("R1 nmi", {31'b0, nmi_irq}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 rxd/cts", {30'b0, per_rxd, per_cts_n}, 32'h3);
        @(negedge clk);
        run_chk = 1;

        // R2 readback and high bits
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 dir high bits", v, 32'h3FFF);
        wr(8'h04, 32'h0000_1234); rd(8'h04, v); chk("R2 dir readback", v, 32'h1234);
        chk("R4 oe from dir", {18'b0, pad_oe}, 32'h1234);
        wr(8'h08, 32'h0000_2A0F); idle(1);
        chk("R4 out from data", {18'b0, pad_out}, 32'h2A0F);

        // R3 unmapped
        wr(8'h18, 32'hFFFF_FFFF); wr(8'h1F, 32'hFFFF_FFFF);
        rd(8'h18, v); chk("R3 unmapped 0x18", v, 32'h0);
        rd(8'hFC, v); chk("R3 unmapped 0xFC", v, 32'h0);
        rd(8'h06, v); chk("R3 low addr bits ignored", v, 32'h1234);
        rd(8'h14, v); chk("R3 enable untouched", v, 32'h0);

        // R6 all pins match level 0
        rd(8'h10, v); chk("R6 status all set", v, 32'h3FFF);
        chk("R8 nmi off without enable", {31'b0, nmi_irq}, 32'h0);
        wr(8'h14, 32'h4); idle(1);
        chk("R8 nmi on", {31'b0, nmi_irq}, 32'h1);

        // R7 clear, write-zero, set priority
        wr(8'h10, 32'h0); rd(8'h10, v); chk("R7 write zero no effect", v, 32'h3FFF);
        pad_in = 14'h0001;
        wr(8'h0C, 32'h3FFF); idle(4);
        wr(8'h10, 32'h3FFF);
        rd(8'h10, v); chk("R7 clear with set priority", v, 32'h0001);
        chk("R8 nmi off after clear", {31'b0, nmi_irq}, 32'h0);
        rd(8'h10, v); chk("R6 status sticky after clear", v, 32'h0001);

        // R5 synchroniser delay
        pad_in = 14'h2A5A;
        rd(8'h08, v); chk("R5 old value before sync", v, 32'h0001);
        idle(3);
        rd(8'h08, v); chk("R5 synced pin data", v, 32'h2A5A);

        // R9 / R11 alternate functions
        per_txd = 1'b1; per_rts_n = 1'b0; per_addr = 4'hA;
        wr(8'h00, 32'h3FFF); idle(1);
        chk("R9 alt oe", {18'b0, pad_oe[7:0]} , 32'hF5);
        chk("R9 alt out", {18'b0, pad_out[7:0]}, 32'hA1);
        chk("R11 unmapped alt pins", {18'b0, pad_oe[13:8], pad_out[13:8]}, 32'h0);
        pad_in = 14'h0002; idle(3);
        chk("R10 rxd follows pin1", {31'b0, per_rxd}, 32'h1);
        chk("R10 cts_n follows pin3", {31'b0, per_cts_n}, 32'h0);
        wr(8'h00, 32'h0); idle(1);
        chk("R10 idle when gpio", {30'b0, per_rxd, per_cts_n}, 32'h3);

        // Random phase, compared cycle by cycle against the model
        for (int it = 0; it < 4000; it++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0, 1: wr(8'(($urandom % 8) * 4 + ($urandom % 4)), $urandom);
                2, 3: rd(8'(($urandom % 8) * 4), v);
                4: begin pad_in = NP'($urandom); idle(1); end
                default: begin
                    per_txd = 1'($urandom); per_rts_n = 1'($urandom);
                    per_addr = 4'($urandom); idle(1);
                end
            endcase
        end
        idle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule